// File: doc/BRIEF.md
# Space Vector Duty Calculator

This block turns a stationary two-axis voltage reference into three per-phase duty values for a three-phase inverter modulator. The reference arrives as a pair of signed Q15 components, d and q. The block forms three projections of the reference. It takes a three-bit sector code from the signs of the phase references and uses that code to choose two active-vector times and the order in which the phases receive them. The zero-vector time is split evenly, so the active interval sits in the middle of the period. Each duty is a Q15 value between 0 and 0x7FFF.

One reference is accepted per handshake on the input side. Its three duties appear on the output side one cycle later, marked by an output valid. The output stage holds a single result. A new reference is accepted when that stage is empty, or when the stage is being emptied in the same cycle (in_ready = !out_valid || out_ready). While out_valid is high and out_ready is low, in_ready stays low and the presented result does not change. Carrier generation, dead time and any later shaping stage are outside this block.

Top module: `svm_duty_calc`

## Requirements
- R1: The projections are P0 = q, P1 = bits [31:16] of (q·2^15 + d·28377) and P2 = bits [31:16] of (q·2^15 − d·28377). Both products are 32-bit signed, so taking the upper half rounds toward minus infinity.
- R2: The sector code has three bits. Bit 0 is set when q > 0, bit 1 is set when P2 < 0, and bit 2 is set when P1 < 0. A value of exactly zero leaves its bit clear.
- R3: Sector codes 0 and 7 give ta = tb = tc = 0.
- R4: The active times (t1, t2) depend on the sector code: code 1 gives (P2, P1), code 2 gives (P1, −P0), code 3 gives (−P2, P0), code 4 gives (−P0, P2), code 5 gives (P0, −P1) and code 6 gives (−P1, −P2).
- R5: lo = (0x7FFF − t1 − t2) shifted right arithmetically by one, mid = lo + t1 and hi = mid + t2. The (lo, mid, hi) values go to phases as follows: code 1 gives (tb, ta, tc), code 2 gives (ta, tc, tb), code 3 gives (ta, tb, tc), code 4 gives (tc, tb, ta), code 5 gives (tb, tc, ta) and code 6 gives (tc, ta, tb).
- R6: Each duty is clamped to the range 0 to 0x7FFF. A value below 0 becomes 0, and a value above 0x7FFF becomes 0x7FFF.
- R7: The cycle after a reference is accepted, out_valid is high and carries that reference's duties. When out_ready is high and nothing is accepted, out_valid goes low on the next cycle.
- R8: in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, the output duties stay unchanged.
- R9: After reset, out_valid is low, all duties are 0 and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Reference pair offered |
| in_ready | output | 1 | Block can take a reference this cycle |
| in_d | input | 16 | d component, signed Q15 |
| in_q | input | 16 | q component, signed Q15 |
| out_valid | output | 1 | Duty triple is valid |
| out_ready | input | 1 | Consumer takes the duty triple |
| out_ta | output | 16 | Phase a duty, Q15 from 0 to 0x7FFF |
| out_tb | output | 16 | Phase b duty, Q15 from 0 to 0x7FFF |
| out_tc | output | 16 | Phase c duty, Q15 from 0 to 0x7FFF |

## Verification
The hardest cases to reach from the ports are references that land exactly on a sector edge. In those cases one projection is exactly zero, or it lies just below zero only because of floor rounding. Examples are q = 1 with d = 0, and d = ±1 with q = 0. The bench drives these pairs directly, and it also drives full-scale pairs whose active times exceed a period, which forces the clamp. Random pairs with random back-pressure then cover every sector and every stall pattern against a behavioural model.

// File: rtl/svm_pkg.sv
package svm_pkg;

  // source of an active-vector time
  typedef enum logic [2:0] {
    SRC_P0  = 3'd0,
    SRC_NP0 = 3'd1,
    SRC_P1  = 3'd2,
    SRC_NP1 = 3'd3,
    SRC_P2  = 3'd4,
    SRC_NP2 = 3'd5
  } tsrc_e;

  // position of a phase within the centred pattern
  typedef enum logic [1:0] {
    RANK_LO  = 2'd0,
    RANK_MID = 2'd1,
    RANK_HI  = 2'd2
  } rank_e;

  typedef struct packed {
    logic  is_null;
    tsrc_e first;
    tsrc_e second;
    rank_e rank_a;
    rank_e rank_b;
    rank_e rank_c;
  } rule_t;

  function automatic rule_t rule_of(input logic [2:0] code);
    rule_t r;
    r = '{is_null: 1'b1, first: SRC_P0, second: SRC_P0,
          rank_a: RANK_LO, rank_b: RANK_LO, rank_c: RANK_LO};
    case (code)
      3'd1: r = '{1'b0, SRC_P2,  SRC_P1,  RANK_MID, RANK_LO,  RANK_HI};
      3'd2: r = '{1'b0, SRC_P1,  SRC_NP0, RANK_LO,  RANK_HI,  RANK_MID};
      3'd3: r = '{1'b0, SRC_NP2, SRC_P0,  RANK_LO,  RANK_MID, RANK_HI};
      3'd4: r = '{1'b0, SRC_NP0, SRC_P2,  RANK_HI,  RANK_MID, RANK_LO};
      3'd5: r = '{1'b0, SRC_P0,  SRC_NP1, RANK_HI,  RANK_LO,  RANK_MID};
      3'd6: r = '{1'b0, SRC_NP1, SRC_NP2, RANK_MID, RANK_HI,  RANK_LO};
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/svm_project.sv
module svm_project #(
  parameter int DW  = 16,
  parameter int KSQ = 28377
) (
  input  logic signed [DW-1:0] d,
  input  logic signed [DW-1:0] q,
  output logic signed [DW-1:0] p0,
  output logic signed [DW-1:0] p1,
  output logic signed [DW-1:0] p2
);
  localparam int PW = 2 * DW;
  localparam logic signed [DW-1:0] K = DW'(KSQ);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] q_al;
  logic signed [PW-1:0] sum_p;
  logic signed [PW-1:0] sum_m;

  assign prod  = PW'(d) * PW'(K);
  assign q_al  = PW'(q) <<< (DW - 1);
  assign sum_p = q_al + prod;
  assign sum_m = q_al - prod;

  assign p0 = q;
  assign p1 = sum_p[PW-1:DW];
  assign p2 = sum_m[PW-1:DW];
endmodule

// File: rtl/svm_sector.sv
module svm_sector #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] q,
  input  logic signed [DW-1:0] p1,
  input  logic signed [DW-1:0] p2,
  output logic [2:0]           code
);
  // each phase reference strictly positive sets its bit
  assign code[0] = !q[DW-1] && (|q);
  assign code[1] = p2[DW-1];
  assign code[2] = p1[DW-1];
endmodule

// File: rtl/svm_timing.sv
module svm_timing
  import svm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2:0]           code,
  input  logic signed [DW-1:0] p0,
  input  logic signed [DW-1:0] p1,
  input  logic signed [DW-1:0] p2,
  output logic [DW-1:0]        ta,
  output logic [DW-1:0]        tb,
  output logic [DW-1:0]        tc
);
  localparam int WW = DW + 4;
  localparam int NPH = 3;
  localparam logic signed [WW-1:0] ONE = WW'((64'sd1 <<< (DW - 1)) - 64'sd1);

  rule_t rule;
  logic signed [WW-1:0] e0, e1, e2;
  logic signed [WW-1:0] t1, t2;
  logic signed [WW-1:0] ranked [NPH];
  logic [NPH-1:0][DW-1:0] duty;

  assign rule = rule_of(code);
  assign e0 = WW'(p0);
  assign e1 = WW'(p1);
  assign e2 = WW'(p2);

  function automatic logic signed [WW-1:0] pick(
    input tsrc_e s,
    input logic signed [WW-1:0] a0,
    input logic signed [WW-1:0] a1,
    input logic signed [WW-1:0] a2
  );
    logic signed [WW-1:0] v;
    case (s)
      SRC_P0:  v = a0;
      SRC_NP0: v = -a0;
      SRC_P1:  v = a1;
      SRC_NP1: v = -a1;
      SRC_P2:  v = a2;
      SRC_NP2: v = -a2;
      default: v = '0;
    endcase
    return v;
  endfunction

  assign t1 = pick(rule.first,  e0, e1, e2);
  assign t2 = pick(rule.second, e0, e1, e2);

  always_comb begin
    ranked[0] = (ONE - t1 - t2) >>> 1;
    ranked[1] = ranked[0] + t1;
    ranked[2] = ranked[1] + t2;
  end

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    rank_e rk;
    logic signed [WW-1:0] v;
    logic [DW-1:0] clamped;

    always_comb begin
      if (g == 0)      rk = rule.rank_a;
      else if (g == 1) rk = rule.rank_b;
      else             rk = rule.rank_c;
      case (rk)
        RANK_MID: v = ranked[1];
        RANK_HI:  v = ranked[2];
        default:  v = ranked[0];
      endcase
      if (v < 0)        clamped = '0;
      else if (v > ONE) clamped = ONE[DW-1:0];
      else              clamped = v[DW-1:0];
    end

    assign duty[g] = rule.is_null ? '0 : clamped;
  end

  assign ta = duty[0];
  assign tb = duty[1];
  assign tc = duty[2];
endmodule

// File: rtl/svm_duty_calc.sv
module svm_duty_calc #(
  parameter int DW  = 16,
  parameter int KSQ = 28377
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_d,
  input  logic [DW-1:0] in_q,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_ta,
  output logic [DW-1:0] out_tb,
  output logic [DW-1:0] out_tc
);
  logic signed [DW-1:0] p0, p1, p2;
  logic [2:0]           sec_code;
  logic [DW-1:0]        ta_c, tb_c, tc_c;
  logic                 take;

  svm_project #(.DW(DW), .KSQ(KSQ)) u_proj (
    .d (in_d),
    .q (in_q),
    .p0(p0),
    .p1(p1),
    .p2(p2)
  );

  svm_sector #(.DW(DW)) u_sec (
    .q   (in_q),
    .p1  (p1),
    .p2  (p2),
    .code(sec_code)
  );

  svm_timing #(.DW(DW)) u_tim (
    .code(sec_code),
    .p0  (p0),
    .p1  (p1),
    .p2  (p2),
    .ta  (ta_c),
    .tb  (tb_c),
    .tc  (tc_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ta    <= '0;
      out_tb    <= '0;
      out_tc    <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_ta    <= ta_c;
      out_tb    <= tb_c;
      out_tc    <= tc_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/svm_duty_chk.sv
module svm_duty_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_ta,
  input logic [DW-1:0] out_tb,
  input logic [DW-1:0] out_tc,
  input logic [2:0]    sec_code
);
  p_accept_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ta) && $stable(out_tb) && $stable(out_tc));

  p_clamp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_ta[DW-1] && !out_tb[DW-1] && !out_tc[DW-1]);

  p_null_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (sec_code == 3'd0 || sec_code == 3'd7)
    |=> out_ta == '0 && out_tb == '0 && out_tc == '0);
endmodule

bind svm_duty_calc svm_duty_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_ta   (out_ta),
  .out_tb   (out_tb),
  .out_tc   (out_tc),
  .sec_code (sec_code)
);

// File: tb/sim_svm_duty_calc.sv
module sim_svm_duty_calc;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [15:0] in_d = '0;
  logic signed [15:0] in_q = '0;
  logic in_ready, out_valid;
  logic [15:0] out_ta, out_tb, out_tc;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model state
  bit m_valid = 0;
  int m_a = 0, m_b = 0, m_c = 0;
  string m_tag = "R9";

  always #(PERIOD/2) clk = ~clk;

  svm_duty_calc u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_d(in_d), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_ta(out_ta), .out_tb(out_tb), .out_tc(out_tc)
  );

  function automatic int clampq(input int v);
    if (v < 0) return 0;
    if (v > 32767) return 32767;
    return v;
  endfunction

  function automatic void model(input int d, input int q,
                                output int a, output int b, output int c,
                                output string tag);
    longint yl, zl;
    int x, y, z, sec, t1, t2, lo, mid, hi, ra, rb, rc;
    x  = q;
    yl = (longint'(q) * 32768 + longint'(d) * 28377) >>> 16;
    zl = (longint'(q) * 32768 - longint'(d) * 28377) >>> 16;
    y  = int'(yl);
    z  = int'(zl);
    sec = ((q > 0) ? 1 : 0) + ((z < 0) ? 2 : 0) + ((y < 0) ? 4 : 0);
    t1 = 0; t2 = 0;
    case (sec)
      1: begin t1 = z;  t2 = y;  end
      2: begin t1 = y;  t2 = -x; end
      3: begin t1 = -z; t2 = x;  end
      4: begin t1 = -x; t2 = z;  end
      5: begin t1 = x;  t2 = -y; end
      6: begin t1 = -y; t2 = -z; end
      default: ;
    endcase
    lo  = (32767 - t1 - t2) >>> 1;
    mid = lo + t1;
    hi  = mid + t2;
    ra = 0; rb = 0; rc = 0;
    case (sec)
      1: begin rb = lo; ra = mid; rc = hi; end
      2: begin ra = lo; rc = mid; rb = hi; end
      3: begin ra = lo; rb = mid; rc = hi; end
      4: begin rc = lo; rb = mid; ra = hi; end
      5: begin rb = lo; rc = mid; ra = hi; end
      6: begin rc = lo; ra = mid; rb = hi; end
      default: ;
    endcase
    a = clampq(ra); b = clampq(rb); c = clampq(rc);
    if (sec == 0 || sec == 7) tag = "R3";
    else if (a != ra || b != rb || c != rc) tag = "R6";
    else tag = "R1 R2 R4 R5";
  endfunction

  task automatic check_int(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock of stimulus, model update and comparison
  task automatic step(input bit v, input int d, input int q, input bit rdy);
    bit m_ready;
    int a, b, c;
    string tag;
    in_valid  = v;
    in_d      = 16'(d);
    in_q      = 16'(q);
    out_ready = rdy;
    #1;
    m_ready = !m_valid || rdy;
    check_int("R8", "in_ready", int'(in_ready), int'(m_ready));
    if (v && m_ready) begin
      model(int'(in_d), int'(in_q), a, b, c, tag);
      m_valid = 1; m_a = a; m_b = b; m_c = c; m_tag = tag;
    end else if (m_valid && !rdy) begin
      m_tag = "R8";
    end else if (rdy) begin
      m_valid = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check_int("R7", "out_valid", int'(out_valid), int'(m_valid));
    if (m_valid) begin
      check_int(m_tag, "ta", int'(out_ta), m_a);
      check_int(m_tag, "tb", int'(out_tb), m_b);
      check_int(m_tag, "tc", int'(out_tc), m_c);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    check_int("R9", "out_valid", int'(out_valid), 0);
    check_int("R9", "ta", int'(out_ta), 0);
    check_int("R9", "tb", int'(out_tb), 0);
    check_int("R9", "tc", int'(out_tc), 0);
    check_int("R9", "in_ready", int'(in_ready), 1);
    @(negedge clk);

    // R3 null reference, R2 zero-edge cases
    step(1, 0, 0, 1);
    step(1, 1, 0, 1);
    step(1, -1, 0, 1);
    step(1, 0, 1, 1);
    step(1, 0, -1, 1);
    // one reference in each sector (R4, R5)
    step(1, 0, 16384, 1);
    step(1, 0, -16384, 1);
    step(1, 16384, 0, 1);
    step(1, -16384, 0, 1);
    step(1, 12000, 9000, 1);
    step(1, -12000, 9000, 1);
    step(1, 12000, -9000, 1);
    step(1, -12000, -9000, 1);
    // R6 clamp with full-scale references
    step(1, 32767, 32767, 1);
    step(1, -32768, -32768, 1);
    step(1, 32767, -32768, 1);
    step(1, -32768, 0, 1);
    // R8 stall: result held, no acceptance
    step(1, 9000, 3000, 0);
    step(1, -7000, 2000, 0);
    step(1, -7000, 2000, 0);
    step(1, -7000, 2000, 1);
    step(0, 0, 0, 1);
    // R7 drain with nothing offered
    step(0, 0, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, int'($signed(16'($urandom))),
           int'($signed(16'($urandom))), ($urandom % 3) != 0);
    end
    step(0, 0, 0, 1);
    summary();
  end
endmodule